// File: doc/BRIEF.md
# Programmable Output Bit-Lane Mapper

This block is a configurable bit crossbar placed just ahead of a serial output stage. It receives a 20-bit sample from each of two channels (A and B) along with a sample strobe. For every bit slot of every output lane, a stored 7-bit identifier names the sample bit that the slot carries. On each frame strobe the block registers one parallel word per lane, and a downstream serializer shifts that word out.

Software programs the identifiers through a small synchronous write/read port. Each of the three lane modes has its own identifier table, and the `mode_i` input selects which table is live. In two-wire mode all four lanes carry data, and a slot may name a bit of the previous sample as well as of the current one. In one-wire mode only the first lane of each channel carries data. Half-wire mode also uses only the first lane of each channel, but that lane has 40 slots, which go out as two 20-slot halves on alternate frames.

Top module: `bit_lane_mapper`

## Requirements
- R1: After reset, `lanes_o` and `half_o` are 0. Every table entry holds its default identifier; for example, mode 0 lane 0 slot 0 reads 0x6D, mode 0 lane 2 slot 0 reads 0x69, mode 0 lane 1 slot 19 reads 0x46, mode 1 lane 3 slot 19 reads 0x42, mode 2 lane 0 slot 39 reads 0x46 and mode 2 lane 2 slot 20 reads 0x69.
- R2: An identifier is decoded as follows. Bit 6 is the age (1 = current sample, 0 = previous sample) and bit 2 is the channel (1 = A, 0 = B). With k = {id[5:3], id[1:0]}, the slot carries data bit k-2. A slot is driven with 0 when k < 2 or k-2 > 19, and when it names the previous sample in a mode other than two-wire.
- R3: The configuration address is {mode[9:8], lane[7:6], slot[5:0]}. A write stores `cfg_wdata_i` when `cfg_we_i` is high. `cfg_rdata_o` returns the stored identifier for `cfg_addr_i` one cycle later. A write to an address with mode 3 or slot ≥ 40 is ignored, and a read from such an address returns 0.
- R4: In two-wire mode (`mode_i` = 0), all four lanes carry slots 0..19 from the mode-0 table. Slot s of lane l appears at `lanes_o[l*20+s]`.
- R5: In one-wire mode (`mode_i` = 1), lanes 0 and 2 carry slots 0..19 from the mode-1 table, and lanes 1 and 3 are 0.
- R6: In half-wire mode (`mode_i` = 2), lanes 0 and 2 carry table slots 0..19 on one frame and slots 20..39 on the next, alternating. `half_o` is 1 while the word holds the upper half, and lanes 1 and 3 are 0. A frame in any other mode drives `half_o` to 0 and restarts the alternation at the lower half.
- R7: When `smp_vld_i` is high, the inputs become the current sample and the old current sample becomes the previous sample.
- R8: `lanes_o` and `half_o` change only on a clock edge where `frame_i` is high. A frame uses the samples and table entries held before that edge.
- R9: With `mode_i` = 3, a frame drives every lane to 0.
- R10: The default identifier of each slot selects the current sample of the lane's own channel (lanes 0–1 carry A, lanes 2–3 carry B), MSB first: slot s (taken modulo 20) carries bit 19-s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Lane mode: 0 two-wire, 1 one-wire, 2 half-wire, 3 off |
| smp_a_i | input | 20 | Channel A sample |
| smp_b_i | input | 20 | Channel B sample |
| smp_vld_i | input | 1 | Sample strobe |
| frame_i | input | 1 | Frame strobe; loads the output words |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 10 | Configuration address {mode, lane, slot} |
| cfg_wdata_i | input | 7 | Identifier to store |
| cfg_rdata_o | output | 7 | Stored identifier at the previous cycle's address |
| lanes_o | output | 80 | Parallel slot words, lane l at bits l*20 +: 20 |
| half_o | output | 1 | Half-wire word holds the upper slot half |

## Verification
Corrupted table storage or a wrong address decode appears on `cfg_rdata_o` one cycle after the read address is applied. It also appears in the lane word produced by the next frame strobe. A fault in the sample history can only be seen through a slot that names the previous sample, so the bench routes previous-sample bits across channels and checks them on the first frame after the second sample strobe. A half-wire phase that has gone out of step appears on the second frame as a swapped slot half and a wrong `half_o`.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int ID_W      = 7;
  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    MODE_2W  = 2'd0,
    MODE_1W  = 2'd1,
    MODE_HW  = 2'd2,
    MODE_OFF = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic       cur;
    logic       ch_a;
    logic       ok;
    logic [4:0] idx;
  } bit_sel_t;

  function automatic bit_sel_t decode_id(logic [ID_W-1:0] id, int unsigned smp_w);
    bit_sel_t   d;
    logic [4:0] k;
    k      = {id[5:3], id[1:0]};
    d.cur  = id[6];
    d.ch_a = id[2];
    d.ok   = (k >= 5'd2) && ((32'(k) - 32'd2) < smp_w);
    d.idx  = k - 5'd2;
    return d;
  endfunction

  // current sample, own channel, MSB first
  function automatic logic [ID_W-1:0] dflt_id(int unsigned lane, int unsigned slot,
                                               int unsigned lanes, int unsigned slots,
                                               int unsigned smp_w);
    int unsigned     s;
    logic [4:0]      k;
    logic [ID_W-1:0] id;
    s = slot % slots;
    if (s >= smp_w) return '0;
    k     = 5'(smp_w + 1 - s);
    id    = '0;
    id[6] = 1'b1;
    id[5:3] = k[4:2];
    id[2] = (lane < lanes / 2);
    id[1:0] = k[1:0];
    return id;
  endfunction
endpackage

// File: rtl/blm_smp_hist.sv
module blm_smp_hist #(
  parameter int SMP_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] a_i,
  input  logic [SMP_W-1:0] b_i,
  output logic [SMP_W-1:0] cur_a_o,
  output logic [SMP_W-1:0] cur_b_o,
  output logic [SMP_W-1:0] prev_a_o,
  output logic [SMP_W-1:0] prev_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_a_o  <= '0;
      cur_b_o  <= '0;
      prev_a_o <= '0;
      prev_b_o <= '0;
    end else if (vld_i) begin
      prev_a_o <= cur_a_o;
      prev_b_o <= cur_b_o;
      cur_a_o  <= a_i;
      cur_b_o  <= b_i;
    end
  end
endmodule

// File: rtl/blm_cfg_regs.sv
module blm_cfg_regs
  import blm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOTS = 20,
  parameter int SMP_W = 20,
  localparam int MAXS    = 2 * SLOTS,
  localparam int LANE_AW = $clog2(LANES),
  localparam int SLOT_AW = $clog2(MAXS),
  localparam int AW      = 2 + LANE_AW + SLOT_AW,
  localparam int ENT     = NUM_MODES * LANES * MAXS,
  localparam int IDX_W   = $clog2(ENT),
  localparam int GRP     = LANES / 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [ID_W-1:0]             wdata_i,
  output logic [ID_W-1:0]             rdata_o,
  input  lane_mode_e                  mode_i,
  input  logic                        half_i,
  output logic [LANES*SLOTS*ID_W-1:0] ids_o
);
  logic [ID_W-1:0]    tbl_q [ENT];
  logic [1:0]         a_mode;
  logic [LANE_AW-1:0] a_lane;
  logic [SLOT_AW-1:0] a_slot;
  logic               a_ok;
  logic [IDX_W-1:0]   a_idx;

  assign {a_mode, a_lane, a_slot} = addr_i;
  assign a_ok  = (32'(a_mode) < 32'(NUM_MODES)) && (32'(a_slot) < 32'(MAXS))
              && (32'(a_lane) < 32'(LANES));
  assign a_idx = IDX_W'((32'(a_mode) * 32'(LANES) + 32'(a_lane)) * 32'(MAXS) + 32'(a_slot));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENT; e++)
        tbl_q[e] <= dflt_id((e / MAXS) % LANES, e % MAXS, LANES, SLOTS, SMP_W);
      rdata_o <= '0;
    end else begin
      if (we_i && a_ok) tbl_q[a_idx] <= wdata_i;
      rdata_o <= a_ok ? tbl_q[a_idx] : '0;
    end
  end

  // live table selection per slot; only first lane of each channel group in 1w/hw
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int  I2W  = l * MAXS + s;
      localparam int  I1W  = (LANES + l) * MAXS + s;
      localparam int  IHW0 = (2 * LANES + l) * MAXS + s;
      localparam int  IHW1 = IHW0 + SLOTS;
      localparam bit  ONE  = (l % GRP) == 0;
      logic [ID_W-1:0] sel;
      always_comb begin
        unique case (mode_i)
          MODE_2W: sel = tbl_q[I2W];
          MODE_1W: sel = ONE ? tbl_q[I1W] : '0;
          MODE_HW: sel = ONE ? (half_i ? tbl_q[IHW1] : tbl_q[IHW0]) : '0;
          default: sel = '0;
        endcase
      end
      assign ids_o[(l*SLOTS+s)*ID_W +: ID_W] = sel;
    end
  end
endmodule

// File: rtl/blm_slot_sel.sv
module blm_slot_sel
  import blm_pkg::*;
#(
  parameter int SMP_W = 20
) (
  input  logic [ID_W-1:0]  id_i,
  input  logic             two_wire_i,
  input  logic [SMP_W-1:0] cur_a_i,
  input  logic [SMP_W-1:0] cur_b_i,
  input  logic [SMP_W-1:0] prev_a_i,
  input  logic [SMP_W-1:0] prev_b_i,
  output logic             bit_o
);
  bit_sel_t         d;
  logic [SMP_W-1:0] src;

  always_comb begin
    d = decode_id(id_i, SMP_W);
    unique case ({d.cur, d.ch_a})
      2'b11:   src = cur_a_i;
      2'b10:   src = cur_b_i;
      2'b01:   src = prev_a_i;
      default: src = prev_b_i;
    endcase
    bit_o = d.ok && (d.cur || two_wire_i) && src[d.idx];
  end
endmodule

// File: rtl/bit_lane_mapper.sv
module bit_lane_mapper
  import blm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOTS = 20,
  parameter int SMP_W = 20,
  localparam int LW   = LANES * SLOTS,
  localparam int MAXS = 2 * SLOTS,
  localparam int AW   = 2 + $clog2(LANES) + $clog2(MAXS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [SMP_W-1:0] smp_a_i,
  input  logic [SMP_W-1:0] smp_b_i,
  input  logic             smp_vld_i,
  input  logic             frame_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [ID_W-1:0]  cfg_wdata_i,
  output logic [ID_W-1:0]  cfg_rdata_o,
  output logic [LW-1:0]    lanes_o,
  output logic             half_o
);
  lane_mode_e          mode;
  logic                half_q;
  logic [LW*ID_W-1:0]  ids;
  logic [LW-1:0]       slot_bits;
  logic [SMP_W-1:0]    cur_a, cur_b, prev_a, prev_b;

  assign mode = lane_mode_e'(mode_i);

  blm_smp_hist #(.SMP_W(SMP_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (smp_vld_i),
    .a_i      (smp_a_i),
    .b_i      (smp_b_i),
    .cur_a_o  (cur_a),
    .cur_b_o  (cur_b),
    .prev_a_o (prev_a),
    .prev_b_o (prev_b)
  );

  blm_cfg_regs #(.LANES(LANES), .SLOTS(SLOTS), .SMP_W(SMP_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .mode_i  (mode),
    .half_i  (half_q),
    .ids_o   (ids)
  );

  for (genvar i = 0; i < LW; i++) begin : g_sel
    blm_slot_sel #(.SMP_W(SMP_W)) u_sel (
      .id_i       (ids[i*ID_W +: ID_W]),
      .two_wire_i (mode == MODE_2W),
      .cur_a_i    (cur_a),
      .cur_b_i    (cur_b),
      .prev_a_i   (prev_a),
      .prev_b_i   (prev_b),
      .bit_o      (slot_bits[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lanes_o <= '0;
      half_o  <= 1'b0;
      half_q  <= 1'b0;
    end else if (frame_i) begin
      lanes_o <= slot_bits;
      half_o  <= (mode == MODE_HW) && half_q;
      half_q  <= (mode == MODE_HW) ? ~half_q : 1'b0;
    end
  end
endmodule

// File: rtl/blm_checker.sv
module blm_checker
  import blm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOTS = 20,
  parameter int SMP_W = 20,
  localparam int LW   = LANES * SLOTS,
  localparam int MAXS = 2 * SLOTS,
  localparam int SAW  = $clog2(MAXS),
  localparam int AW   = 2 + $clog2(LANES) + SAW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             frame_i,
  input logic [AW-1:0]    cfg_addr_i,
  input logic [ID_W-1:0]  cfg_rdata_o,
  input logic [LW-1:0]    lanes_o,
  input logic             half_o
);
  function automatic logic [LW-1:0] idle_mask();
    logic [LW-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++)
      if ((l % (LANES / 2)) != 0) m[l*SLOTS +: SLOTS] = '1;
    return m;
  endfunction
  localparam logic [LW-1:0] IDLE = idle_mask();

  AST_HOLD_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(lanes_o) && $stable(half_o)); // R8
  AST_1W_IDLE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode_i == MODE_1W) |=> (lanes_o & IDLE) == '0); // R5
  AST_HW_IDLE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode_i == MODE_HW) |=> (lanes_o & IDLE) == '0); // R6
  AST_HALF_ONLY_HW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode_i != MODE_HW) |=> !half_o); // R6
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode_i == MODE_OFF) |=> lanes_o == '0); // R9
  AST_BAD_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cfg_addr_i[SAW-1:0]) >= 32'(MAXS) || cfg_addr_i[AW-1 -: 2] == 2'd3)
    |=> cfg_rdata_o == '0); // R3
endmodule

bind bit_lane_mapper blm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .frame_i     (frame_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .lanes_o     (lanes_o),
  .half_o      (half_o)
);

// File: tb/bit_lane_mapper_test.sv
module bit_lane_mapper_test;
  localparam int LANES = 4, SLOTS = 20, MAXS = 40, LW = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [19:0] sa, sb;
  logic        svld, frame, we;
  logic [9:0]  addr;
  logic [6:0]  wdata, rdata;
  logic [LW-1:0] lanes;
  logic        half;

  always #10 clk = ~clk;

  bit_lane_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .smp_a_i(sa), .smp_b_i(sb),
    .smp_vld_i(svld), .frame_i(frame), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .lanes_o(lanes), .half_o(half)
  );

  typedef struct {
    int            due;
    bit            is_rd;
    logic [LW-1:0] lanes;
    logic          half;
    logic [6:0]    rd;
    string         req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_run = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference state built from the requirements
  logic [6:0]    m_tbl [3*LANES*MAXS];
  logic [19:0]   m_ca, m_cb, m_pa, m_pb;
  logic          m_half;
  logic [LW-1:0] m_last;
  logic          m_last_half;

  function automatic logic [9:0] a(int md, int l, int s);
    return {2'(md), 2'(l), 6'(s)};
  endfunction

  function automatic logic m_bit(logic [6:0] id, logic [1:0] md);
    int k;
    logic [19:0] src;
    k = {id[5:3], id[1:0]};
    if (k < 2 || k - 2 > 19) return 1'b0;
    if (!id[6] && md != 2'd0) return 1'b0;
    src = id[2] ? (id[6] ? m_ca : m_pa) : (id[6] ? m_cb : m_pb);
    return src[k-2];
  endfunction

  function automatic logic [LW-1:0] m_lanes(logic [1:0] md, logic hf);
    logic [LW-1:0] r;
    logic [6:0] id;
    r = '0;
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < SLOTS; s++) begin
        id = 7'h00;
        if (md == 2'd0) id = m_tbl[l*MAXS + s];
        else if (md == 2'd1 && l % 2 == 0) id = m_tbl[(LANES+l)*MAXS + s];
        else if (md == 2'd2 && l % 2 == 0) id = m_tbl[(2*LANES+l)*MAXS + s + (hf ? 20 : 0)];
        r[l*SLOTS + s] = m_bit(id, md);
      end
    return r;
  endfunction

  task automatic m_reset();
    logic [4:0] k;
    for (int md = 0; md < 3; md++)
      for (int l = 0; l < LANES; l++)
        for (int s = 0; s < MAXS; s++) begin
          k = 5'(19 - (s % 20) + 2);
          m_tbl[(md*LANES+l)*MAXS + s] = {1'b1, k[4:2], (l < 2), k[1:0]};
        end
    m_ca = '0; m_cb = '0; m_pa = '0; m_pb = '0;
    m_half = 1'b0; m_last = '0; m_last_half = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (e.due != cyc) begin
        n_fail++;
        $display("FAIL %s: check missed its cycle (act %0d exp %0d)", e.req, cyc, e.due);
      end else if (e.is_rd) begin
        if (rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s: rdata act %h exp %h", e.req, rdata, e.rd);
        end
      end else if (lanes !== e.lanes || half !== e.half) begin
        n_fail++;
        $display("FAIL %s: lanes act %h/%b exp %h/%b", e.req, lanes, half, e.lanes, e.half);
      end
    end
  end

  task automatic push_lanes(logic [LW-1:0] l, logic h, string req);
    exp_t e;
    e.due = cyc + 1; e.is_rd = 1'b0; e.lanes = l; e.half = h; e.rd = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic do_sample(logic [19:0] va, logic [19:0] vb);
    @(negedge clk);
    sa = va; sb = vb; svld = 1'b1;
    m_pa = m_ca; m_pb = m_cb; m_ca = va; m_cb = vb;
    @(negedge clk);
    svld = 1'b0;
  endtask

  task automatic do_write(logic [9:0] ad, logic [6:0] d);
    @(negedge clk);
    addr = ad; wdata = d; we = 1'b1;
    if (ad[9:8] != 2'd3 && ad[5:0] < 6'd40)
      m_tbl[(int'(ad[9:8])*LANES + int'(ad[7:6]))*MAXS + int'(ad[5:0])] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_read(logic [9:0] ad, logic [6:0] ex, string req);
    exp_t e;
    @(negedge clk);
    addr = ad;
    e.due = cyc + 1; e.is_rd = 1'b1; e.lanes = '0; e.half = 1'b0; e.rd = ex; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic do_frame(logic [1:0] md, string req);
    logic hf;
    @(negedge clk);
    mode = md; frame = 1'b1;
    hf = (md == 2'd2) ? m_half : 1'b0;
    m_last = m_lanes(md, hf);
    m_last_half = hf;
    m_half = (md == 2'd2) ? ~m_half : 1'b0;
    push_lanes(m_last, m_last_half, req);
    @(negedge clk);
    frame = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung (act timeout exp finish)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; sa = '0; sb = '0; svld = 1'b0; frame = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_lanes('0, 1'b0, "R1 reset outputs");
    @(negedge clk);

    // R1 / R10: default identifiers
    do_read(a(0,0,0),  7'h6D, "R1 default m0 l0 s0");
    do_read(a(0,2,0),  7'h69, "R1 default m0 l2 s0");
    do_read(a(0,1,19), 7'h46, "R10 default m0 l1 s19");
    do_read(a(1,3,19), 7'h42, "R10 default m1 l3 s19");
    do_read(a(2,0,39), 7'h46, "R10 default m2 l0 s39");
    do_read(a(2,2,20), 7'h69, "R10 default m2 l2 s20");

    // R10: default routing in two-wire mode
    do_sample(20'hABCDE, 20'h12345);
    do_frame(2'd0, "R10 default two-wire frame");

    // R4 R2 R7: cross-channel, previous sample and invalid identifiers
    do_sample(20'h5A5A5, 20'hF0F0F);
    do_write(a(0,1,0), 7'h2D);   // prev A D19
    do_write(a(0,3,5), 7'h06);   // prev A D0 on a B lane
    do_write(a(0,0,1), 7'h00);   // k=0, invalid
    do_write(a(0,0,2), 7'h2F);   // k=23, invalid
    do_write(a(0,2,3), 7'h6D);   // cur A MSB on a B lane
    do_write(a(0,3,7), 7'h29);   // prev B D19
    do_frame(2'd0, "R4 R2 R7 two-wire remap");

    // R3: config port
    do_write(a(0,0,45), 7'h11);
    do_read(a(0,0,45), 7'h00, "R3 slot beyond range reads 0");
    do_write(a(3,0,0), 7'h55);
    do_read(a(3,0,0), 7'h00, "R3 mode 3 reads 0");
    do_read(a(0,3,5), 7'h06, "R3 readback");
    do_read(a(0,0,2), 7'h2F, "R3 readback invalid id");
    do_frame(2'd0, "R3 ignored writes leave routing");

    // R5: one-wire
    do_write(a(1,0,3), 7'h06);   // prev outside two-wire -> 0
    do_write(a(1,2,4), 7'h46);
    do_write(a(1,1,0), 7'h6D);   // inactive lane
    do_frame(2'd1, "R5 one-wire frame");

    // R6: half-wire alternation
    do_write(a(2,0,20), 7'h69);
    do_write(a(2,2,39), 7'h2D);
    do_write(a(2,0,5),  7'h42);
    do_frame(2'd2, "R6 half-wire lower");
    do_frame(2'd2, "R6 half-wire upper");
    do_frame(2'd2, "R6 half-wire lower again");
    do_frame(2'd0, "R6 leave half-wire");
    do_frame(2'd2, "R6 restart at lower half");

    // R8: no frame, no change
    do_sample(20'h0F0F0, 20'h33333);
    do_write(a(2,0,0), 7'h00);
    repeat (3) @(negedge clk);
    push_lanes(m_last, m_last_half, "R8 hold without frame");
    @(negedge clk);
    do_frame(2'd2, "R8 R7 next frame uses new state");

    // R9
    do_frame(2'd3, "R9 mode off");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL all: %0d checks pending (act %0d exp 0)", q.size(), q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule